// File: doc/BRIEF.md
# Neighbour-Aware Core Start Allocator

This block decides which of sixteen processing cores is started when software asks for one core or for two cores that sit next to each other. It holds one occupancy bit per core. A single-core request is granted one free core. A dual-core request is granted two adjacent free cores. Both bits of a dual grant are set on the same clock edge, so no other request can take half of the pair. A stop strobe with a core index clears that core's bit when the core is shut down.

The search does not simply take the lowest free core. It ranks the free cores by the state of their neighbours, and neighbours wrap around, so core 15 and core 0 are adjacent. Single requests fill isolated gaps and the edges of running groups first. This leaves whole idle pairs for later dual requests. A mode input restricts dual grants to aligned even/odd pairs. In that mode a single request goes first to a free core whose partner is already running. Results are registered and appear one cycle after the request, as a grant strobe with one or two indices, or as a failure strobe.

Top module: `core_start_alloc`

## Requirements
- R1: After reset every core is free and grant_vld and fail are low. The first single request then receives core 0.
- R2: In adjacent mode a single request first takes a free core whose lower and upper neighbours are both running.
- R3: If no core matches R2, a single request takes a free core N whose core N-1 is running and whose core N+1 is free.
- R4: If no core matches R2 or R3, a single request takes the lowest-numbered free core. Within any tier the lowest index wins.
- R5: In adjacent mode a dual request first takes free cores N and N+1 where core N-1 is running.
- R6: If no pair matches R5, a dual request takes the lowest N whose cores N and N+1 are both free.
- R7: With pair_mode high, a dual request is granted only an aligned pair (2k, 2k+1), so grant_idx is even.
- R8: With pair_mode high, a single request prefers a free core whose partner (index XOR 1) is running over a core whose partner is also free.
- R9: A dual grant reports grant_dual high, with grant_idx2 equal to grant_idx+1 modulo 16. Both cores become occupied at once, and no granted core is granted again until it is stopped.
- R10: Results appear in the cycle after the request. At most one request is served per cycle. When both request inputs are high, only the dual request is served.
- R11: When no core or pair fits, fail pulses for one cycle, grant_vld stays low, and the occupancy is unchanged.
- R12: A stop strobe frees the indexed core. From the next cycle that core can be granted again.
- R13: Neighbour checks wrap around circularly, so core 15 and core 0 are neighbours for every tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | 1: dual grants only aligned even/odd pairs; 0: any adjacent pair |
| single_req | input | 1 | Request one core this cycle |
| dual_req | input | 1 | Request two adjacent cores this cycle |
| stop_vld | input | 1 | Free the core named by stop_idx |
| stop_idx | input | 4 | Core to free |
| grant_vld | output | 1 | Grant strobe, one cycle after the request |
| grant_dual | output | 1 | The grant covers two cores |
| grant_idx | output | 4 | Granted core, or the lower core of a dual grant |
| grant_idx2 | output | 4 | Upper core of a dual grant (equals grant_idx for a single grant) |
| fail | output | 1 | The request in the previous cycle could not be served |

## Verification
A wrong occupancy bit shows at the ports on the next request that reaches that core's neighbourhood. A bit wrongly set makes the tier search skip a free core, or report fail while cores are still free. A bit wrongly cleared hands out a core that is already running, so the same index is granted twice. Either fault shows in the first grant after it, one cycle after the request. A wrong tier mask or a wrong wrap-around term shows as a different index on a crafted occupancy pattern, in the very next grant.

// File: rtl/core_alloc_pkg.sv
package core_alloc_pkg;

  // Outcome of one allocation cycle
  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_SINGLE = 2'd1,
    OUT_DUAL   = 2'd2,
    OUT_FAIL   = 2'd3
  } alloc_out_e;

  // Circular successor of a core index
  function automatic int unsigned succ_idx(input int unsigned i, input int unsigned n);
    return (i + 1) % n;
  endfunction

  // Circular predecessor of a core index
  function automatic int unsigned pred_idx(input int unsigned i, input int unsigned n);
    return (i + n - 1) % n;
  endfunction

endpackage

// File: rtl/alloc_lowest.sv
// Lowest-index set bit of a vector.
module alloc_lowest #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/alloc_tier_select.sv
// Picks the lowest index of the first non-empty tier (tier 0 first).
module alloc_tier_select #(
  parameter int W  = 16,
  parameter int NT = 3,
  localparam int IW = $clog2(W)
) (
  input  logic [NT-1:0][W-1:0] tiers,
  output logic                 hit,
  output logic [IW-1:0]        idx
);

  logic [NT-1:0]         t_hit;
  logic [NT-1:0][IW-1:0] t_idx;

  for (genvar t = 0; t < NT; t++) begin : g_tier
    alloc_lowest #(.W(W)) u_low (
      .vec (tiers[t]),
      .hit (t_hit[t]),
      .idx (t_idx[t])
    );
  end

  always_comb begin
    hit = |t_hit;
    idx = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (t_hit[t]) idx = t_idx[t];
    end
  end

endmodule

// File: rtl/alloc_cand.sv
// Builds the preference-tier candidate masks from the occupancy vector.
module alloc_cand
  import core_alloc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              pair_mode,
  input  logic [W-1:0]      occ,
  output logic [2:0][W-1:0] s_tiers,
  output logic [1:0][W-1:0] d_tiers
);

  for (genvar i = 0; i < W; i++) begin : g_core
    localparam int UP = int'(succ_idx(i, W));
    localparam int DN = int'(pred_idx(i, W));
    localparam int PT = (i ^ 1) % W;
    localparam bit EVEN = (i % 2) == 0;

    logic free_c;
    assign free_c = ~occ[i];

    always_comb begin
      if (pair_mode) begin
        s_tiers[0][i] = free_c & occ[PT];
        s_tiers[1][i] = 1'b0;
        s_tiers[2][i] = free_c;
        d_tiers[0][i] = 1'b0;
        d_tiers[1][i] = EVEN & free_c & ~occ[UP];
      end else begin
        s_tiers[0][i] = free_c & occ[DN] & occ[UP];
        s_tiers[1][i] = free_c & occ[DN] & ~occ[UP];
        s_tiers[2][i] = free_c;
        d_tiers[0][i] = free_c & ~occ[UP] & occ[DN];
        d_tiers[1][i] = free_c & ~occ[UP];
      end
    end
  end

endmodule

// File: rtl/core_start_alloc.sv
module core_start_alloc
  import core_alloc_pkg::*;
#(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_mode,
  input  logic          single_req,
  input  logic          dual_req,
  input  logic          stop_vld,
  input  logic [IW-1:0] stop_idx,
  output logic          grant_vld,
  output logic          grant_dual,
  output logic [IW-1:0] grant_idx,
  output logic [IW-1:0] grant_idx2,
  output logic          fail
);

  logic [W-1:0]      occ_q, occ_d;
  logic [2:0][W-1:0] s_tiers;
  logic [1:0][W-1:0] d_tiers;
  logic              s_hit, d_hit;
  logic [IW-1:0]     s_idx, d_idx, d_nxt;
  logic [W-1:0]      stop_mask, grant_mask;
  alloc_out_e        outcome;
  logic              idx_en;
  logic [IW-1:0]     idx_d, idx2_d;

  alloc_cand #(.W(W)) u_cand (
    .pair_mode (pair_mode),
    .occ       (occ_q),
    .s_tiers   (s_tiers),
    .d_tiers   (d_tiers)
  );

  alloc_tier_select #(.W(W), .NT(3)) u_single (
    .tiers (s_tiers),
    .hit   (s_hit),
    .idx   (s_idx)
  );

  alloc_tier_select #(.W(W), .NT(2)) u_dual (
    .tiers (d_tiers),
    .hit   (d_hit),
    .idx   (d_idx)
  );

  assign d_nxt = (d_idx == IW'(W - 1)) ? '0 : d_idx + 1'b1;

  // Next-state
  always_comb begin
    outcome    = OUT_IDLE;
    grant_mask = '0;
    stop_mask  = '0;
    idx_en     = 1'b0;
    idx_d      = grant_idx;
    idx2_d     = grant_idx2;
    if (stop_vld) stop_mask[stop_idx] = 1'b1;
    if (dual_req) begin
      if (d_hit) begin
        outcome           = OUT_DUAL;
        grant_mask[d_idx] = 1'b1;
        grant_mask[d_nxt] = 1'b1;
        idx_en            = 1'b1;
        idx_d             = d_idx;
        idx2_d            = d_nxt;
      end else begin
        outcome = OUT_FAIL;
      end
    end else if (single_req) begin
      if (s_hit) begin
        outcome           = OUT_SINGLE;
        grant_mask[s_idx] = 1'b1;
        idx_en            = 1'b1;
        idx_d             = s_idx;
        idx2_d            = s_idx;
      end else begin
        outcome = OUT_FAIL;
      end
    end
    occ_d = (occ_q & ~stop_mask) | grant_mask;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q      <= '0;
      grant_vld  <= 1'b0;
      grant_dual <= 1'b0;
      fail       <= 1'b0;
      grant_idx  <= '0;
      grant_idx2 <= '0;
    end else begin
      occ_q      <= occ_d;
      grant_vld  <= (outcome == OUT_SINGLE) || (outcome == OUT_DUAL);
      grant_dual <= (outcome == OUT_DUAL);
      fail       <= (outcome == OUT_FAIL);
      if (idx_en) begin
        grant_idx  <= idx_d;
        grant_idx2 <= idx2_d;
      end
    end
  end

endmodule

// File: rtl/core_alloc_chk.sv
module core_alloc_chk #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pair_mode,
  input logic          single_req,
  input logic          dual_req,
  input logic          stop_vld,
  input logic [IW-1:0] stop_idx,
  input logic          grant_vld,
  input logic          grant_dual,
  input logic [IW-1:0] grant_idx,
  input logic [IW-1:0] grant_idx2,
  input logic          fail,
  input logic [W-1:0]  occ_q
);

  logic [W-1:0]  occ_prev;
  logic [IW-1:0] idx_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_prev <= '0;
    else        occ_prev <= occ_q;
  end

  assign idx_up = (grant_idx == IW'(W - 1)) ? '0 : grant_idx + 1'b1;

  // R11
  grant_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && fail));

  // R11
  fail_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !$past(stop_vld) |-> occ_q == $past(occ_q));

  // R10
  result_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld || fail) |-> $past(single_req || dual_req));

  // R10
  dual_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && $past(dual_req) |-> grant_dual);

  // R9
  pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_dual |-> grant_idx2 == idx_up);

  // R9
  granted_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !occ_prev[grant_idx] && occ_q[grant_idx] && occ_q[grant_idx2]);

  // R7
  pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_dual && $past(pair_mode) |-> !grant_idx[0]);

  // R12
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_vld |=> !occ_q[$past(stop_idx)]);

endmodule

bind core_start_alloc core_alloc_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_mode  (pair_mode),
  .single_req (single_req),
  .dual_req   (dual_req),
  .stop_vld   (stop_vld),
  .stop_idx   (stop_idx),
  .grant_vld  (grant_vld),
  .grant_dual (grant_dual),
  .grant_idx  (grant_idx),
  .grant_idx2 (grant_idx2),
  .fail       (fail),
  .occ_q      (occ_q)
);

// File: tb/sim_core_start_alloc.sv
`timescale 1ns/1ps
module sim_core_start_alloc;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pair_mode, single_req, dual_req, stop_vld;
  logic [3:0] stop_idx;
  logic       grant_vld, grant_dual, fail;
  logic [3:0] grant_idx, grant_idx2;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  core_start_alloc u0 (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
    .single_req(single_req), .dual_req(dual_req),
    .stop_vld(stop_vld), .stop_idx(stop_idx),
    .grant_vld(grant_vld), .grant_dual(grant_dual),
    .grant_idx(grant_idx), .grant_idx2(grant_idx2), .fail(fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pair_mode = 1'b0; single_req = 1'b0; dual_req = 1'b0;
    stop_vld = 1'b0; stop_idx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drives one request cycle; outputs are sampled one cycle later.
  task automatic req(input logic s, input logic d);
    @(negedge clk);
    single_req = s; dual_req = d;
    @(negedge clk);
    single_req = 1'b0; dual_req = 1'b0;
  endtask

  task automatic stop(input int idx);
    @(negedge clk);
    stop_vld = 1'b1; stop_idx = 4'(idx);
    @(negedge clk);
    stop_vld = 1'b0;
  endtask

  // Reset, occupy all 16 cores, then free the cores not in busy.
  task automatic setup(input logic [15:0] busy);
    do_reset();
    for (int i = 0; i < 16; i++) req(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) if (!busy[i]) stop(i);
  endtask

  task automatic expect_single(input string tag, input int idx);
    chk({tag, " grant_vld"}, grant_vld, 1);
    chk({tag, " grant_dual"}, grant_dual, 0);
    chk({tag, " grant_idx"}, grant_idx, idx);
  endtask

  task automatic expect_dual(input string tag, input int idx, input int idx2);
    chk({tag, " grant_vld"}, grant_vld, 1);
    chk({tag, " grant_dual"}, grant_dual, 1);
    chk({tag, " grant_idx"}, grant_idx, idx);
    chk({tag, " grant_idx2"}, grant_idx2, idx2);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 grant_vld after reset", grant_vld, 0);
    chk("R1 fail after reset", fail, 0);
    req(1'b1, 1'b0);
    expect_single("R1/R4 first single", 0);
    req(1'b1, 1'b0);
    expect_single("R3 edge of running group", 1);
  endtask

  task automatic t_single_tiers();
    setup(~16'h0620);            // free: 5, 9, 10
    req(1'b1, 1'b0);
    expect_single("R2 sandwiched core", 5);
    req(1'b1, 1'b0);
    expect_single("R3/R4 lowest of tier", 9);
    setup(16'h4001);             // busy: 0, 14
    req(1'b1, 1'b0);
    expect_single("R13 wrap sandwich", 15);
  endtask

  task automatic t_dual();
    setup(16'h0008);             // busy: 3
    req(1'b0, 1'b1);
    expect_dual("R5 preferred pair", 4, 5);
    setup(~16'h8001);            // free: 15, 0
    req(1'b0, 1'b1);
    expect_dual("R13 wrapped pair", 15, 0);
    do_reset();
    req(1'b0, 1'b1);
    expect_dual("R6 fallback pair", 0, 1);
    req(1'b0, 1'b1);
    expect_dual("R9 no regrant", 2, 3);
  endtask

  task automatic t_priority();
    do_reset();
    req(1'b1, 1'b1);
    expect_dual("R10 dual wins", 0, 1);
    @(negedge clk);
    chk("R10 single not also served", grant_vld, 0);
    req(1'b1, 1'b0);
    expect_single("R10 single after dual", 2);
  endtask

  task automatic t_pair_mode();
    setup(16'h0001);             // busy: 0
    pair_mode = 1'b1;
    req(1'b0, 1'b1);
    expect_dual("R7 aligned pair", 2, 3);
    setup(16'h0020);             // busy: 5
    pair_mode = 1'b1;
    req(1'b1, 1'b0);
    expect_single("R8 partner running", 4);
    pair_mode = 1'b0;
  endtask

  task automatic t_fail_stop();
    setup(16'hFFFF);
    req(1'b1, 1'b0);
    chk("R11 single fail", fail, 1);
    chk("R11 no grant", grant_vld, 0);
    req(1'b0, 1'b1);
    chk("R11 dual fail", fail, 1);
    stop(7);
    req(1'b1, 1'b0);
    expect_single("R12 freed core regranted", 7);
    chk("R12 fail low", fail, 0);
    setup(~16'h0024);            // free: 2, 5
    req(1'b0, 1'b1);
    chk("R11 dual no pair", fail, 1);
    req(1'b1, 1'b0);
    expect_single("R11 occupancy kept a", 2);
    req(1'b1, 1'b0);
    expect_single("R11 occupancy kept b", 5);
    req(1'b1, 1'b0);
    chk("R11 full again", fail, 1);
  endtask

  initial begin
    t_reset();
    t_single_tiers();
    t_dual();
    t_priority();
    t_pair_mode();
    t_fail_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule